// File: doc/BRIEF.md
# Eight-Input ADC Register Front End

This block sits between a register bus and an eight-input successive-approximation converter. Software programs a control register with a one-hot input select, a clock divider, a power-up bit and a start code. The block derives the conversion clock from the peripheral clock and runs one conversion per start request. It then stores the 12-bit result in two places: a global data register, which also records the source input, and the data register of that input.

Each data register keeps its own DONE and OVERRUN flags. A read clears the flags of the register that was read and leaves every other copy alone. An interrupt line follows the global DONE flag when its enable bit is set. The analog converter is modelled by a digital stub. The stub returns the value on the matching slice of `ana_in` on the cycle the result is written.

The register port is a plain strobe interface with no back-pressure. A write takes effect at the clock edge where `reg_wr` is high. `reg_rdata` is combinational from `reg_addr` and is valid in the same cycle. A cycle with `reg_rd` high counts as a read, and it clears flags at that edge. Word addresses are: 0 control, 1 global data, 2 interrupt enable, 8 to 15 the data registers of inputs 0 to 7. Any other address reads zero.

Top module: `adc_frontend`

## Requirements
- R1: After reset every register reads zero. The control register holds the input select in bits 7:0, the divider in bits 15:8, power-up in bit 21 and the start code in bits 26:24, and reads back as written. Once a start code of 001 has been seen, the start field reads 000.
- R2: A start request that begins a conversion produces a result written 1 + 11*(divider+1) clock cycles after the write edge.
- R3: While power-up is clear, a start code of 001 starts nothing, and the start field still returns to 000.
- R4: A conversion uses the lowest set bit of the select field. It writes the stub sample of that input into bits 15:4 and the input number into bits 26:24 of the global register. An all-zero select starts nothing.
- R5: In the data registers bit 31 is DONE and bit 30 is OVERRUN. Bits 15:4 hold the result, and every bit not named here reads zero.
- R6: Reading a data register clears its DONE and OVERRUN at that edge. The value returned is the value before clearing.
- R7: A result written into a register whose DONE is still set sets OVERRUN in that register. A read in the same cycle as the write counts as earlier, and then OVERRUN stays clear.
- R8: The global register and each channel register keep independent flags. A read of one never changes another.
- R9: A start request made while a conversion is in progress is ignored. The running conversion keeps its input and its timing.
- R10: `irq` is high exactly while the global DONE bit is set and bit 0 of the interrupt enable register is set.
- R11: A start code other than 001 starts no conversion and stays in the control register as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears flags) |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| ana_in | input | 96 | Stub samples, input i in bits 12*i+11:12*i |
| irq | output | 1 | Interrupt, level high |

## Verification
The assertions check four rules on every cycle. The divider counter is held at zero while powered down. A running conversion keeps its input. OVERRUN never stands without DONE in the global register. A global read clears its flags while leaving unwritten channel registers untouched. Only the bench scenarios can show the rest. These are the exact write-to-result latency at several dividers, the lowest-bit input choice, and the overrun sequence built from two unread results. They also cover the discard of starts while busy or powered down, and the interrupt level following global DONE, checked against a flag model over a seeded random mix of inputs, dividers and reads.

// File: rtl/adcfe_pkg.sv
package adcfe_pkg;
  localparam int NCH   = 8;
  localparam int RES   = 12;
  localparam int CHW   = $clog2(NCH);
  localparam int DIV_W = 8;
  localparam int AW    = 4;

  localparam logic [AW-1:0] A_CTRL  = 4'd0;
  localparam logic [AW-1:0] A_GDATA = 4'd1;
  localparam logic [AW-1:0] A_INTEN = 4'd2;

  localparam int SEL_LSB   = 0;
  localparam int DIV_LSB   = 8;
  localparam int PWR_BIT   = 21;
  localparam int START_LSB = 24;
  localparam int CHF_LSB   = 24;
  localparam int RES_LSB   = 4;
  localparam int OVR_BIT   = 30;
  localparam int DONE_BIT  = 31;

  localparam logic [2:0] START_NOW = 3'b001;

  typedef struct packed {
    logic           done;
    logic           ovr;
    logic [RES-1:0] res;
  } slot_t;
endpackage

// File: rtl/adcfe_clkdiv.sv
module adcfe_clkdiv
  import adcfe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!en || restart)   cnt <= '0;
    else if (cnt == div)       cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  assign tick = en && !restart && (cnt == div);

  // R3: powered down holds the divider at zero
  assert_div_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
endmodule

// File: rtl/adcfe_seq.sv
module adcfe_seq
  import adcfe_pkg::*;
#(
  parameter int CONV_CLKS = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_req,
  input  logic           pwr,
  input  logic [NCH-1:0] sel,
  input  logic           tick,
  output logic           conv_go,
  output logic           busy,
  output logic [CHW-1:0] ch,
  output logic           complete
);
  localparam int CW = $clog2(CONV_CLKS + 1);

  logic [CW-1:0]  cnt;
  logic [CHW-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (sel[i]) pick = CHW'(i);
  end

  assign conv_go  = start_req && pwr && (|sel) && !busy;
  assign complete = busy && tick && (cnt == CW'(CONV_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      ch   <= '0;
    end else if (conv_go) begin
      busy <= 1'b1;
      cnt  <= '0;
      ch   <= pick;
    end else if (complete) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy && tick) begin
      cnt  <= cnt + 1'b1;
    end
  end

  // R9: a running conversion keeps its input until it finishes
  assert_busy_keeps_ch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !complete) |=> (busy && $stable(ch)));
endmodule

// File: rtl/adcfe_stub.sv
module adcfe_stub
  import adcfe_pkg::*;
(
  input  logic [NCH*RES-1:0] ana_in,
  input  logic [CHW-1:0]     ch,
  output logic [RES-1:0]     sample
);
  assign sample = ana_in[int'(ch)*RES +: RES];
endmodule

// File: rtl/adcfe_bank.sv
module adcfe_bank
  import adcfe_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [CHW-1:0]     wch,
  input  logic [RES-1:0]     wres,
  input  logic               rd_g,
  input  logic [NCH-1:0]     rd_c,
  output slot_t              g,
  output logic [CHW-1:0]     g_ch,
  output slot_t [NCH-1:0]    c
);
  slot_t gq;
  slot_t cq [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gq   <= '0;
      g_ch <= '0;
    end else if (wr) begin
      gq.done <= 1'b1;
      gq.ovr  <= rd_g ? 1'b0 : (gq.ovr | gq.done);
      gq.res  <= wres;
      g_ch    <= wch;
    end else if (rd_g) begin
      gq.done <= 1'b0;
      gq.ovr  <= 1'b0;
    end
  end

  assign g = gq;

  for (genvar i = 0; i < NCH; i++) begin : g_slot
    logic hit;
    assign hit = wr && (wch == CHW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cq[i] <= '0;
      end else if (hit) begin
        cq[i].done <= 1'b1;
        cq[i].ovr  <= rd_c[i] ? 1'b0 : (cq[i].ovr | cq[i].done);
        cq[i].res  <= wres;
      end else if (rd_c[i]) begin
        cq[i].done <= 1'b0;
        cq[i].ovr  <= 1'b0;
      end
    end

    assign c[i] = cq[i];

    // R8: a global read leaves an unwritten channel register untouched
    assert_chan_indep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_g && !hit && !rd_c[i]) |=> $stable(cq[i]));
  end

  // R6: a global read with no write clears both global flags
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_g && !wr) |=> (!gq.done && !gq.ovr));

  // R7: overrun never stands without done
  assert_ovr_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gq.ovr |-> gq.done);
endmodule

// File: rtl/adc_frontend.sv
module adc_frontend
  import adcfe_pkg::*;
#(
  parameter int CONV_CLKS = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [AW-1:0]      reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NCH*RES-1:0] ana_in,
  output logic               irq
);
  logic [NCH-1:0]   sel_q;
  logic [DIV_W-1:0] div_q;
  logic             pwr_q;
  logic [2:0]       start_q;
  logic             inten_q;

  logic wr_ctrl, start_req, tick, conv_go, busy, complete;
  logic [CHW-1:0] conv_ch, g_ch;
  logic [RES-1:0] sample;
  logic           rd_g;
  logic [NCH-1:0] rd_c;
  slot_t          g;
  slot_t [NCH-1:0] c;

  assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
  assign start_req = (start_q == START_NOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      div_q   <= '0;
      pwr_q   <= 1'b0;
      start_q <= '0;
      inten_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        sel_q   <= reg_wdata[SEL_LSB +: NCH];
        div_q   <= reg_wdata[DIV_LSB +: DIV_W];
        pwr_q   <= reg_wdata[PWR_BIT];
        start_q <= reg_wdata[START_LSB +: 3];
      end else if (start_req) begin
        start_q <= '0;
      end
      if (reg_wr && (reg_addr == A_INTEN)) inten_q <= reg_wdata[0];
    end
  end

  adcfe_clkdiv u_div (
    .clk(clk), .rst_n(rst_n), .en(pwr_q), .restart(conv_go),
    .div(div_q), .tick(tick)
  );

  adcfe_seq #(.CONV_CLKS(CONV_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .pwr(pwr_q),
    .sel(sel_q), .tick(tick), .conv_go(conv_go), .busy(busy),
    .ch(conv_ch), .complete(complete)
  );

  adcfe_stub u_stub (.ana_in(ana_in), .ch(conv_ch), .sample(sample));

  assign rd_g = reg_rd && (reg_addr == A_GDATA);
  always_comb begin
    for (int i = 0; i < NCH; i++)
      rd_c[i] = reg_rd && reg_addr[AW-1] && (reg_addr[CHW-1:0] == CHW'(i));
  end

  adcfe_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr(complete), .wch(conv_ch), .wres(sample),
    .rd_g(rd_g), .rd_c(rd_c), .g(g), .g_ch(g_ch), .c(c)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL) begin
      reg_rdata[SEL_LSB +: NCH]   = sel_q;
      reg_rdata[DIV_LSB +: DIV_W] = div_q;
      reg_rdata[PWR_BIT]          = pwr_q;
      reg_rdata[START_LSB +: 3]   = start_q;
    end else if (reg_addr == A_GDATA) begin
      reg_rdata[DONE_BIT]         = g.done;
      reg_rdata[OVR_BIT]          = g.ovr;
      reg_rdata[CHF_LSB +: CHW]   = g_ch;
      reg_rdata[RES_LSB +: RES]   = g.res;
    end else if (reg_addr == A_INTEN) begin
      reg_rdata[0]                = inten_q;
    end else if (reg_addr[AW-1]) begin
      reg_rdata[DONE_BIT]         = c[reg_addr[CHW-1:0]].done;
      reg_rdata[OVR_BIT]          = c[reg_addr[CHW-1:0]].ovr;
      reg_rdata[RES_LSB +: RES]   = c[reg_addr[CHW-1:0]].res;
    end
  end

  assign irq = g.done && inten_q;

  // R3: no conversion is running unless powered at its start
  assert_go_powered_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pwr_q));
endmodule

// File: tb/tb_adc_frontend.sv
module tb_adc_frontend;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [95:0] ana_in = '0;
  logic        irq;

  int n_chk = 0, n_err = 0;
  bit done_flag = 0;

  logic        m_gd, m_go;
  logic [2:0]  m_gch;
  logic [11:0] m_gres;
  logic        m_cd [8];
  logic        m_co [8];
  logic [11:0] m_cres [8];

  always #10 clk = ~clk;

  adc_frontend dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ana_in(ana_in), .irq(irq)
  );

  function automatic logic [31:0] ctrl_word(input logic [7:0] sel, input logic [7:0] dv,
                                            input logic pw, input logic [2:0] st);
    return {5'b0, st, 2'b0, pw, 5'b0, dv, sel};
  endfunction

  function automatic logic [31:0] gword();
    return {m_gd, m_go, 3'b0, m_gch, 8'b0, m_gres, 4'b0};
  endfunction

  function automatic logic [31:0] cword(input int i);
    return {m_cd[i], m_co[i], 14'b0, m_cres[i], 4'b0};
  endfunction

  function automatic int lowest(input logic [7:0] sel);
    int r = -1;
    for (int i = 7; i >= 0; i--) if (sel[i]) r = i;
    return r;
  endfunction

  function automatic int lat(input int dv);
    return 1 + 11 * (dv + 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
    if (a == 4'd1) begin m_gd = 0; m_go = 0; end
    if (a >= 4'd8) begin m_cd[a-8] = 0; m_co[a-8] = 0; end
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(v === exp, tag, v, exp);
  endtask

  task automatic model_write(input int ch);
    logic [11:0] s = ana_in[ch*12 +: 12];
    m_go = m_go | m_gd; m_gd = 1; m_gch = 3'(ch); m_gres = s;
    m_co[ch] = m_co[ch] | m_cd[ch]; m_cd[ch] = 1; m_cres[ch] = s;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic conv(input logic [7:0] sel, input int dv);
    wr(4'd0, ctrl_word(sel, 8'(dv), 1'b1, 3'b001));
    idle(lat(dv) + 1);
    model_write(lowest(sel));
  endtask

  task automatic timed(input logic [7:0] sel, input int dv, input string tag);
    int n = 0;
    wr(4'd0, ctrl_word(sel, 8'(dv), 1'b1, 3'b001));
    while (!irq && n < 1000) begin @(posedge clk); #1; n++; end
    chk(n == lat(dv), tag, 32'(n), 32'(lat(dv)));
    model_write(lowest(sel));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4711));
    m_gd = 0; m_go = 0; m_gch = 0; m_gres = 0;
    for (int i = 0; i < 8; i++) begin m_cd[i] = 0; m_co[i] = 0; m_cres[i] = 0; end
    for (int i = 0; i < 8; i++) ana_in[i*12 +: 12] = 12'(16'h0A1 * (i + 1));
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 / R5 / R10 reset state
    rd_chk(4'd0, 32'h0, "R1 ctrl after reset");
    rd_chk(4'd1, 32'h0, "R5 global after reset");
    rd_chk(4'd9, 32'h0, "R5 channel1 after reset");
    chk(irq === 1'b0, "R10 irq after reset", 32'(irq), 32'h0);

    // R1 readback, R11 non-trigger start code kept and inert
    wr(4'd0, ctrl_word(8'h04, 8'd5, 1'b1, 3'b011));
    idle(100);
    rd_chk(4'd0, ctrl_word(8'h04, 8'd5, 1'b1, 3'b011), "R1 R11 ctrl readback");
    rd_chk(4'd1, gword(), "R11 no conversion from code 011");

    // R2 latency and R10 interrupt
    wr(4'd2, 32'h1);
    rd_chk(4'd2, 32'h1, "R10 enable readback");
    timed(8'h01, 0, "R2 latency div0");
    rd_chk(4'd0, ctrl_word(8'h01, 8'd0, 1'b1, 3'b000), "R1 start field self-clears");
    chk(irq === 1'b1, "R10 irq follows done", 32'(irq), 32'h1);
    rd_chk(4'd1, gword(), "R4 R5 global word ch0");
    chk(irq === 1'b0, "R10 irq drops after read", 32'(irq), 32'h0);
    timed(8'h08, 3, "R2 latency div3");
    rd_chk(4'd1, gword(), "R4 global word ch3");
    wr(4'd2, 32'h0);
    conv(8'h02, 1);
    chk(irq === 1'b0, "R10 irq masked", 32'(irq), 32'h0);
    rd_chk(4'd1, gword(), "R6 global read");
    rd_chk(4'd1, gword(), "R6 global cleared after read");

    // R3 powered down
    wr(4'd0, ctrl_word(8'h40, 8'd0, 1'b0, 3'b001));
    idle(40);
    rd_chk(4'd0, ctrl_word(8'h40, 8'd0, 1'b0, 3'b000), "R3 start discarded when off");
    rd_chk(4'd14, cword(6), "R3 no conversion when off");
    rd_chk(4'd1, gword(), "R3 global untouched when off");

    // R4 zero select and lowest bit
    wr(4'd0, ctrl_word(8'h00, 8'd0, 1'b1, 3'b001));
    idle(40);
    rd_chk(4'd1, gword(), "R4 zero select starts nothing");
    conv(8'h14, 0);
    rd_chk(4'd1, gword(), "R4 lowest select bit ch2");
    rd_chk(4'd12, cword(4), "R4 ch4 not written");
    rd_chk(4'd10, cword(2), "R4 ch2 written");

    // R7 overrun, R8 independence
    rd_chk(4'd11, cword(3), "R6 clear ch3");
    ana_in[3*12 +: 12] = 12'h123;
    conv(8'h08, 0);
    ana_in[3*12 +: 12] = 12'hFED;
    conv(8'h08, 0);
    rd_chk(4'd1, gword(), "R7 global overrun");
    rd_chk(4'd1, gword(), "R6 global cleared");
    rd_chk(4'd11, cword(3), "R7 R8 channel overrun kept");
    conv(8'h08, 1);
    rd_chk(4'd11, cword(3), "R8 channel fresh done");
    rd_chk(4'd1, gword(), "R8 global done kept");

    // R9 start while busy
    wr(4'd2, 32'h1);
    begin
      int n = 0;
      wr(4'd0, ctrl_word(8'h02, 8'd1, 1'b1, 3'b001));
      while (!irq && n < 1000) begin
        if (n == 5) wr(4'd0, ctrl_word(8'h20, 8'd1, 1'b1, 3'b001));
        else begin @(posedge clk); #1; end
        n++;
      end
      chk(n == lat(1), "R9 busy start keeps timing", 32'(n), 32'(lat(1)));
      model_write(1);
    end
    idle(60);
    rd_chk(4'd1, gword(), "R9 busy start keeps input");
    rd_chk(4'd13, cword(5), "R9 ignored start wrote nothing");

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [7:0] sel = 8'($urandom_range(1, 255));
      int dv = $urandom_range(0, 3);
      int k = $urandom_range(0, 3);
      for (int i = 0; i < 8; i++) ana_in[i*12 +: 12] = 12'($urandom);
      conv(sel, dv);
      if (k == 0) rd_chk(4'd1, gword(), "R4 R7 random global");
      else if (k == 1) rd_chk(4'(8 + lowest(sel)), cword(lowest(sel)), "R5 R7 random channel");
      else if (k == 2) begin
        int c = $urandom_range(0, 7);
        rd_chk(4'(8 + c), cword(c), "R8 random other channel");
      end
      chk(irq === m_gd, "R10 random irq", 32'(irq), 32'(m_gd));
    end

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule